// File: doc/BRIEF.md
# Read-to-Lock Semaphore Bank

A bank of one-bit hardware semaphores that lets one of several software agents take exclusive use of a pair of mailbox slots. An agent acquires a semaphore by reading it. The read is an atomic test-and-set: it returns the value the semaphore held and leaves it locked. A returned 0 means the agent now owns it. A returned 1 means another agent already held it. The owner gives the semaphore back by writing 1 to it. A write of 0 never changes anything.

The bank has a read channel and a write channel. Each channel has an address and an addressing-mode bit. In direct mode the address is the semaphore index. In slot mode the address is a mailbox slot index, and the semaphore guarding that slot is taken as (slot + 1) >> 1. Read data comes back one cycle after the read as a 32-bit word. The lock state of every semaphore is also driven out continuously. Only one read is accepted per cycle, and that is what makes the test-and-set atomic across all requesters.

Top module: `sem_bank`

## Requirements
- R1: After reset every semaphore is free (`sem_locked` all 0) and `rd_valid` is 0.
- R2: A read of a free semaphore returns 0 in `rd_data` one cycle later, and the semaphore shows locked in `sem_locked` from that same cycle.
- R3: A read of a locked semaphore returns 1 and the semaphore stays locked.
- R4: A write whose `wr_data` bit 0 is 1 frees a locked semaphore; `sem_locked` shows it free one cycle after the write.
- R5: A write whose `wr_data` bit 0 is 0 changes no semaphore. A write of any value to a free semaphore leaves it free.
- R6: When a read and a write target the same semaphore in one cycle, the write takes effect first, and the read returns and acts on the resulting value.
- R7: With the mode bit at 1 (slot mode), the address selects semaphore (address + 1) >> 1. With the mode bit at 0 (direct mode), the address is the semaphore index.
- R8: An access whose resolved index is N or more is ignored. Such a read still raises `rd_valid` and returns 0, and no semaphore changes.
- R9: `rd_valid` is high exactly one cycle after `rd_en`. `rd_data` bits 31:1 are always 0, and `rd_data` is 0 whenever `rd_valid` is low.
- R10: A read and a write to different semaphores in the same cycle both take effect, independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Test-and-set read request |
| rd_by_slot | input | 1 | Read address mode: 1 = slot index, 0 = semaphore index |
| rd_addr | input | AW (5) | Read address |
| wr_en | input | 1 | Write request |
| wr_by_slot | input | 1 | Write address mode: 1 = slot index, 0 = semaphore index |
| wr_addr | input | AW (5) | Write address |
| wr_data | input | 32 | Write data; only bit 0 is used (1 = release) |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | 32 | Value the semaphore held when it was read, in bit 0 |
| sem_locked | output | N (16) | Lock state of every semaphore, bit i for semaphore i |

## Verification
Every result is due exactly one clock edge after the request that causes it. This holds for the read word, the valid flag, and the locked or freed state in `sem_locked`. The bench drives each request on a falling edge and lets one rising edge pass. It then samples all outputs one time unit later and compares them against a behavioural model. The model applies the write before the read within each cycle. This one-edge latency also covers same-cycle read and write pairs, slot-mode mapping and out-of-range addresses.

// File: rtl/sem_bank_pkg.sv
package sem_bank_pkg;

  typedef enum logic {
    ADDR_SEM  = 1'b0,
    ADDR_SLOT = 1'b1
  } addr_mode_e;

  // semaphore guarding a mailbox slot pair
  function automatic int slot_to_sem(input int slot);
    return (slot + 1) >> 1;
  endfunction

  // resolve an address under a mode to a raw semaphore number
  function automatic int resolve_index(input addr_mode_e mode, input int addr);
    return (mode == ADDR_SLOT) ? slot_to_sem(addr) : addr;
  endfunction

  // release request is carried in bit 0 of write data
  function automatic logic is_release(input logic [31:0] data);
    return data[0];
  endfunction

endpackage

// File: rtl/sem_addr_decode.sv
module sem_addr_decode
  import sem_bank_pkg::*;
#(
  parameter int N  = 16,
  parameter int AW = 5,
  parameter int IW = 4
) (
  input  logic          en,
  input  logic          by_slot,
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  sel
);
  int raw;

  always_comb begin
    raw = resolve_index(addr_mode_e'(by_slot), int'(addr));
    hit = (raw < N);
    idx = hit ? IW'(raw) : '0;
    sel = '0;
    if (en && hit) sel[idx] = 1'b1;
  end
endmodule

// File: rtl/sem_cell.sv
module sem_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic acquire,
  input  logic release_req,
  output logic locked,
  output logic seen
);
  logic locked_q;

  // write is applied before the read looks at the value
  assign seen = locked_q & ~release_req;

  always_ff @(posedge clk) begin
    if (!rst_n) locked_q <= 1'b0;
    else        locked_q <= seen | acquire;
  end

  assign locked = locked_q;
endmodule

// File: rtl/sem_read_port.sv
module sem_read_port #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          rd_hit,
  input  logic [IW-1:0] rd_idx,
  input  logic [N-1:0]  seen_vec,
  output logic          rd_valid,
  output logic [31:0]   rd_data
);
  logic old_bit;

  assign old_bit = rd_hit ? seen_vec[rd_idx] : 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= {31'd0, rd_en & old_bit};
    end
  end
endmodule

// File: rtl/sem_bank.sv
module sem_bank
  import sem_bank_pkg::*;
#(
  parameter int N  = 16,
  parameter int AW = $clog2(2 * N),
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          rd_by_slot,
  input  logic [AW-1:0] rd_addr,
  input  logic          wr_en,
  input  logic          wr_by_slot,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  output logic          rd_valid,
  output logic [31:0]   rd_data,
  output logic [N-1:0]  sem_locked
);
  logic          rd_hit, wr_hit;
  logic [IW-1:0] rd_idx, wr_idx;
  logic [N-1:0]  acquire_vec, wr_sel_vec, release_vec, seen_vec;
  logic          wr_release;

  sem_addr_decode #(.N(N), .AW(AW), .IW(IW)) u_rd_dec (
    .en(rd_en), .by_slot(rd_by_slot), .addr(rd_addr),
    .hit(rd_hit), .idx(rd_idx), .sel(acquire_vec)
  );

  sem_addr_decode #(.N(N), .AW(AW), .IW(IW)) u_wr_dec (
    .en(wr_en), .by_slot(wr_by_slot), .addr(wr_addr),
    .hit(wr_hit), .idx(wr_idx), .sel(wr_sel_vec)
  );

  assign wr_release  = is_release(wr_data);
  assign release_vec = wr_release ? wr_sel_vec : '0;

  for (genvar i = 0; i < N; i++) begin : g_cell
    sem_cell u_cell (
      .clk(clk), .rst_n(rst_n),
      .acquire(acquire_vec[i]), .release_req(release_vec[i]),
      .locked(sem_locked[i]), .seen(seen_vec[i])
    );
  end

  sem_read_port #(.N(N), .IW(IW)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_hit(rd_hit),
    .rd_idx(rd_idx), .seen_vec(seen_vec),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: rtl/sem_bank_checker.sv
module sem_bank_checker #(
  parameter int N  = 16,
  parameter int AW = 5,
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_en,
  input logic          wr_en,
  input logic [31:0]   wr_data,
  input logic          rd_hit,
  input logic          wr_hit,
  input logic [IW-1:0] rd_idx,
  input logic [IW-1:0] wr_idx,
  input logic          rd_valid,
  input logic [31:0]   rd_data,
  input logic [N-1:0]  sem_locked
);
  logic same_target;
  assign same_target = rd_en && rd_hit && wr_en && wr_hit && (rd_idx == wr_idx);

  assert_read_free_locks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_hit && !same_target && !sem_locked[rd_idx])
    |=> (rd_valid && rd_data == 32'd0 && sem_locked[$past(rd_idx)]));

  assert_one_new_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sem_locked & ~$past(sem_locked)) <= 1);

  assert_read_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_hit && !same_target && sem_locked[rd_idx])
    |=> (rd_data == 32'd1 && sem_locked[$past(rd_idx)]));

  assert_release_frees_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_hit && wr_data[0] && !(rd_en && rd_hit && rd_idx == wr_idx))
    |=> !sem_locked[$past(wr_idx)]);

  assert_zero_write_inert_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_hit && wr_data[0]) |=> (($past(sem_locked) & ~sem_locked) == '0));

  assert_write_then_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (same_target && wr_data[0]) |=> (rd_data == 32'd0 && sem_locked[$past(rd_idx)]));

  assert_out_of_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_hit) |=> (rd_valid && rd_data == 32'd0));

  assert_valid_timing_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rd_valid == $past(rd_en)));

  assert_data_shape_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[31:1] == 31'd0) && (rd_valid || rd_data == 32'd0));
endmodule

bind sem_bank sem_bank_checker #(.N(N), .AW(AW), .IW(IW)) u_sem_bank_checker (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
  .rd_hit(rd_hit), .wr_hit(wr_hit), .rd_idx(rd_idx), .wr_idx(wr_idx),
  .rd_valid(rd_valid), .rd_data(rd_data), .sem_locked(sem_locked)
);

// File: tb/sem_bank_bench.sv
module sem_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 16;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_en = 1'b0, rd_by_slot = 1'b0, wr_en = 1'b0, wr_by_slot = 1'b0;
  logic [AW-1:0] rd_addr = '0, wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic          rd_valid;
  logic [31:0]   rd_data;
  logic [N-1:0]  sem_locked;

  int vectors = 0;
  int fails = 0;
  bit model_lock[N];

  always #(CLK_PERIOD / 2) clk = ~clk;

  sem_bank #(.N(N), .AW(AW)) u_sem_bank (
    .clk(clk), .rst_n(rst_n),
    .rd_en(rd_en), .rd_by_slot(rd_by_slot), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_by_slot(wr_by_slot), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .sem_locked(sem_locked)
  );

  function automatic int target(input logic by_slot, input int a);
    if (by_slot) return (a + 1) / 2;
    return a;
  endfunction

  function automatic logic [N-1:0] model_vec();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = model_lock[i];
    return v;
  endfunction

  task automatic compare(input string tag, input logic ev, input logic [31:0] ed);
    vectors++;
    if (rd_valid !== ev || rd_data !== ed || sem_locked !== model_vec()) begin
      fails++;
      $display("FAIL %s: valid=%0b data=%0h locked=%04h expected valid=%0b data=%0h locked=%04h",
               tag, rd_valid, rd_data, sem_locked, ev, ed, model_vec());
    end
  endtask

  task automatic step(input logic re, input logic rs, input int ra,
                      input logic we, input logic ws, input int wa,
                      input logic [31:0] wd, input string tag);
    logic [31:0] ed;
    int ri, wi;
    @(negedge clk);
    rd_en = re; rd_by_slot = rs; rd_addr = AW'(ra);
    wr_en = we; wr_by_slot = ws; wr_addr = AW'(wa); wr_data = wd;
    ed = '0;
    wi = target(ws, wa);
    ri = target(rs, ra);
    if (we && wi < N && wd[0]) model_lock[wi] = 1'b0;
    if (re && ri < N) begin
      ed = {31'd0, model_lock[ri]};
      model_lock[ri] = 1'b1;
    end
    @(posedge clk);
    #1;
    compare(tag, re, ed);
    rd_en = 1'b0; wr_en = 1'b0;
  endtask

  task automatic rd(input logic s, input int a, input string tag);
    step(1'b1, s, a, 1'b0, 1'b0, 0, 32'd0, tag);
  endtask

  task automatic wr(input logic s, input int a, input logic [31:0] d, input string tag);
    step(1'b0, 1'b0, 0, 1'b1, s, a, d, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < N; i++) model_lock[i] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    compare("R1 reset state", 1'b0, 32'd0);

    rd(1'b0, 3, "R2 read free sem 3");
    rd(1'b0, 3, "R3 read locked sem 3");
    wr(1'b0, 3, 32'hFFFF_FFFE, "R5 write bit0=0 keeps lock");
    wr(1'b0, 3, 32'd1, "R4 write 1 frees sem 3");
    wr(1'b0, 5, 32'd1, "R5 write 1 to free sem 5");
    wr(1'b0, 6, 32'd0, "R5 write 0 to free sem 6");
    rd(1'b0, 3, "R2 reacquire sem 3");
    step(1'b0, 1'b0, 0, 1'b0, 1'b0, 0, 32'd0, "R9 idle cycle");

    rd(1'b1, 0, "R7 slot 0 -> sem 0");
    rd(1'b1, 1, "R7 slot 1 -> sem 1");
    rd(1'b1, 2, "R7 slot 2 -> sem 1 locked");
    rd(1'b1, 30, "R7 slot 30 -> sem 15");
    wr(1'b1, 29, 32'd1, "R7 release slot 29 -> sem 15");
    rd(1'b1, 31, "R8 slot 31 out of range");
    rd(1'b0, 20, "R8 direct 20 out of range");
    wr(1'b0, 17, 32'd1, "R8 out of range write");

    rd(1'b0, 7, "R2 lock sem 7");
    step(1'b1, 1'b0, 7, 1'b1, 1'b0, 7, 32'd1, "R6 read+release same sem 7");
    step(1'b1, 1'b0, 7, 1'b1, 1'b0, 7, 32'd0, "R6 read+zero write same sem 7");
    step(1'b1, 1'b0, 9, 1'b1, 1'b0, 7, 32'd1, "R10 read 9 and release 7");

    lfsr = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], lfsr[1], int'(lfsr[6:2]), lfsr[7], lfsr[8], int'(lfsr[13:9]),
           {31'd0, lfsr[14]}, "R10 mixed traffic");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule